// File: doc/BRIEF.md
# Serial SAR converter conversion and readout controller

This block sits on the host side of one or more 14-bit successive-approximation converters that share a four-wire serial link: a convert strobe, a serial clock, a host-driven serial line into the converters and a serial data line back from them. While the run input is high, it starts conversions at a fixed pace. Before each start it sets the host-to-converter line to pick the interface mode. It waits out the worst-case conversion time, then clocks the result in most significant bit first. All timing is set by nanosecond parameters, which are rounded up to whole system-clock cycles.

There are two modes. In select mode a single converter is read: the strobe is high only during conversion, then low to enable the converter's output. In chain mode N converters are cascaded and read as one N×14-bit stream, with the strobe held high throughout. Each 14-bit word is delivered as a one-cycle valid pulse, together with the index of the converter it came from.

Top module: `sar_rd_ctrl`

## Requirements
- R1: While rst_ni is low, cnv_o, sck_o, sdi_o and res_valid_o are low. Nothing starts until run_i is seen high after reset.
- R2: At every rising edge of cnv_o, sdi_o is high when select mode was chosen (chain_i=0) and low when chain mode was chosen (chain_i=1). It has been stable for at least T_SDI_SU_NS before that edge.
- R3: No sck_o rising edge comes earlier than T_CONV_NS after the cnv_o rising edge. sck_o is low for at least 5 ns before and 8 ns after that edge.
- R4: In select mode, cnv_o is high for the conversion wait only, and stays low for the whole readout.
- R5: In chain mode, cnv_o stays high from the conversion start until the last readout clock.
- R6: Each sck_o high phase lasts at least HI_C cycles and each low phase at least LO_C cycles. The sck_o period is at least 29 ns, and each sample is taken at least T_DSDO_NS after the previous falling edge.
- R7: Each conversion gives exactly 14 falling sck_o edges in select mode and 14×N_DEV in chain mode. sdo_i is sampled at the system-clock edge where sck_o falls, and the first sample is the MSB.
- R8: Every 14 sampled bits produce a one-cycle res_valid_o pulse. res_data_o holds the first sampled bit at bit 13. dev_idx_o is 0 for the converter wired to sdo_i and rises by one for each converter further upstream.
- R9: Successive cnv_o rising edges are at least T_CYC_NS apart. Each comes at least T_ACQ_NS after the last sck_o falling edge of the previous readout.
- R10: With run_i low no conversion starts. A conversion already started when run_i falls still completes and delivers all of its words.
- R11: chain_i is taken only when a conversion is about to start. A change during a conversion does not alter that conversion's mode, bit count or words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Level enabling continuous conversion |
| chain_i | input | 1 | 1 selects chain mode, 0 select mode |
| cnv_o | output | 1 | Convert strobe to the converters |
| sck_o | output | 1 | Serial clock to the converters |
| sdi_o | output | 1 | Mode-select / chain-head data line |
| sdo_i | input | 1 | Serial data from the converters |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | DW | Result word, MSB first bit |
| dev_idx_o | output | IW | Index of the converter the word came from |

## Verification
The hardest case to reach is a conversion in flight when run_i drops or chain_i flips. The bench waits for the modelled converters to see a convert edge, then changes these inputs in the middle of the conversion wait. It then checks the words and the falling-edge count of that conversion against the mode sampled at its start. A mid-conversion reset is reached the same way. Converter models built as shift registers check each timing minimum in real time on every edge.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_CONV, ST_EN, ST_SHIFT, ST_ACQ
  } st_e;

  function automatic int unsigned cdiv(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sar_rd_sck.sv
module sar_rd_sck #(
  parameter int unsigned HI = 3,
  parameter int unsigned LO = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sck_o,
  output logic fall_o
);
  localparam int unsigned CW = $clog2(((HI > LO) ? HI : LO) + 1);

  logic [CW-1:0] cnt_q;
  logic          sck_q;
  logic          flip;

  assign flip   = sck_q ? (cnt_q == CW'(HI - 1)) : (cnt_q == CW'(LO - 1));
  assign fall_o = en_i && sck_q && flip;
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cnt_q <= '0;
    end else if (!en_i) begin
      sck_q <= 1'b0;
      cnt_q <= '0;
    end else if (flip) begin
      sck_q <= !sck_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sar_rd_deser.sv
module sar_rd_deser #(
  parameter int unsigned DW    = 14,
  parameter int unsigned N_DEV = 2,
  parameter int unsigned IW    = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          smp_i,
  input  logic          bit_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic [IW-1:0] idx_o
);
  localparam int unsigned BW = $clog2(DW);

  logic [DW-1:0] sh_q;
  logic [BW-1:0] cnt_q;
  logic [IW-1:0] dev_q;
  logic [DW-1:0] nxt;

  assign nxt = {sh_q[DW-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      dev_q   <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
      idx_o   <= '0;
    end else begin
      valid_o <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
        dev_q <= '0;
      end else if (smp_i) begin
        sh_q <= nxt;
        if (cnt_q == BW'(DW - 1)) begin
          cnt_q   <= '0;
          valid_o <= 1'b1;
          data_o  <= nxt;
          idx_o   <= dev_q;
          dev_q   <= dev_q + 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sar_rd_seq.sv
module sar_rd_seq
  import sar_rd_pkg::*;
#(
  parameter int unsigned SETUP_C = 8,
  parameter int unsigned CONV_C  = 800,
  parameter int unsigned EN_C    = 6,
  parameter int unsigned ACQ_C   = 450,
  parameter int unsigned CYC_C   = 1250,
  parameter int unsigned DW      = 14,
  parameter int unsigned N_DEV   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic chain_i,
  input  logic fall_i,
  output logic sck_en_o,
  output logic cnv_o,
  output logic sdi_o,
  output logic clr_o,
  output logic mode_o
);
  localparam int unsigned WMAX = umax(umax(SETUP_C, CONV_C), umax(EN_C, ACQ_C));
  localparam int unsigned CW   = $clog2(WMAX + 1);
  localparam int unsigned PW   = $clog2(CYC_C + 1);
  localparam int unsigned NB   = DW * N_DEV;
  localparam int unsigned BW   = $clog2(NB + 1);

  st_e           st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] per_q;
  logic [BW-1:0] bit_q, bit_d, last_bit;
  logic          mode_q, mode_d;

  assign last_bit = mode_q ? BW'(NB - 1) : BW'(DW - 1);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q + 1'b1;
    bit_d  = bit_q;
    mode_d = mode_q;
    case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (run_i) begin
          st_d   = ST_SETUP;
          mode_d = chain_i;
        end
      end
      ST_SETUP: if (cnt_q == CW'(SETUP_C - 1)) begin st_d = ST_CONV; cnt_d = '0; end
      ST_CONV:  if (cnt_q == CW'(CONV_C - 1))  begin st_d = ST_EN;   cnt_d = '0; end
      ST_EN: if (cnt_q == CW'(EN_C - 1)) begin
        st_d  = ST_SHIFT;
        cnt_d = '0;
        bit_d = '0;
      end
      ST_SHIFT: begin
        cnt_d = '0;
        if (fall_i) begin
          if (bit_q == last_bit) st_d = ST_ACQ;
          else bit_d = bit_q + 1'b1;
        end
      end
      ST_ACQ: if (cnt_q >= CW'(ACQ_C - 1)) begin
        cnt_d = cnt_q;
        // pace from the previous start as well as from the end of readout
        if (per_q == PW'(CYC_C)) begin
          cnt_d = '0;
          if (run_i) begin
            st_d   = ST_SETUP;
            mode_d = chain_i;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      per_q  <= '0;
      bit_q  <= '0;
      mode_q <= 1'b0;
      cnv_o  <= 1'b0;
      sdi_o  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      mode_q <= mode_d;
      if (st_d == ST_CONV && st_q != ST_CONV) per_q <= '0;
      else if (per_q != PW'(CYC_C))           per_q <= per_q + 1'b1;
      cnv_o <= (st_d == ST_CONV) || (mode_d && (st_d == ST_EN || st_d == ST_SHIFT));
      sdi_o <= !mode_d && (st_d != ST_IDLE);
    end
  end

  assign sck_en_o = (st_q == ST_SHIFT);
  assign clr_o    = (st_q == ST_SETUP);
  assign mode_o   = mode_q;
endmodule

// File: rtl/sar_rd_ctrl.sv
module sar_rd_ctrl
  import sar_rd_pkg::*;
#(
  parameter int unsigned DW          = 14,
  parameter int unsigned N_DEV       = 2,
  parameter int unsigned CLK_NS      = 4,
  parameter int unsigned T_CONV_NS   = 3200,
  parameter int unsigned T_CYC_NS    = 5000,
  parameter int unsigned T_ACQ_NS    = 1800,
  parameter int unsigned T_SDI_SU_NS = 30,
  parameter int unsigned T_EN_NS     = 22,
  parameter int unsigned T_SCKH_NS   = 12,
  parameter int unsigned T_SCKL_NS   = 12,
  parameter int unsigned T_SCK_NS    = 29,
  parameter int unsigned T_DSDO_NS   = 24,
  localparam int unsigned IW = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          chain_i,
  output logic          cnv_o,
  output logic          sck_o,
  output logic          sdi_o,
  input  logic          sdo_i,
  output logic          res_valid_o,
  output logic [DW-1:0] res_data_o,
  output logic [IW-1:0] dev_idx_o
);
  localparam int unsigned HI_C    = cdiv(T_SCKH_NS, CLK_NS);
  localparam int unsigned PER_C   = umax(cdiv(T_SCK_NS, CLK_NS), cdiv(T_DSDO_NS, CLK_NS) + 1);
  localparam int unsigned LO_C    = umax(cdiv(T_SCKL_NS, CLK_NS), umax(PER_C, HI_C + 1) - HI_C);
  localparam int unsigned SETUP_C = umax(cdiv(T_SDI_SU_NS, CLK_NS), 2);
  localparam int unsigned CONV_C  = cdiv(T_CONV_NS, CLK_NS);
  localparam int unsigned EN_C    = umax(cdiv(T_EN_NS, CLK_NS), 1);
  localparam int unsigned ACQ_C   = umax(cdiv(T_ACQ_NS, CLK_NS), 1);
  localparam int unsigned CYC_C   = cdiv(T_CYC_NS, CLK_NS);

  logic sck_en, fall, clr, mode_w;

  sar_rd_seq #(
    .SETUP_C(SETUP_C), .CONV_C(CONV_C), .EN_C(EN_C), .ACQ_C(ACQ_C),
    .CYC_C(CYC_C), .DW(DW), .N_DEV(N_DEV)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .chain_i(chain_i),
    .fall_i(fall), .sck_en_o(sck_en), .cnv_o(cnv_o), .sdi_o(sdi_o),
    .clr_o(clr), .mode_o(mode_w)
  );

  sar_rd_sck #(.HI(HI_C), .LO(LO_C)) u_sck (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(sck_en), .sck_o(sck_o), .fall_o(fall)
  );

  sar_rd_deser #(.DW(DW), .N_DEV(N_DEV), .IW(IW)) u_deser (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .smp_i(fall), .bit_i(sdo_i),
    .valid_o(res_valid_o), .data_o(res_data_o), .idx_o(dev_idx_o)
  );
endmodule

// File: rtl/sar_rd_chk.sv
module sar_rd_chk #(
  parameter int unsigned N_DEV = 2,
  parameter int unsigned HI_C  = 3,
  parameter int unsigned LO_C  = 5,
  parameter int unsigned IW    = 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cnv_o,
  input logic          sck_o,
  input logic          sdi_o,
  input logic          res_valid_o,
  input logic [IW-1:0] dev_idx_o,
  input logic          mode_i
);
  logic [7:0] hi_len, lo_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_len <= '0;
      lo_len <= '0;
    end else begin
      hi_len <= !sck_o ? 8'd0 : (hi_len == 8'hff ? hi_len : hi_len + 8'd1);
      lo_len <=  sck_o ? 8'd0 : (lo_len == 8'hff ? lo_len : lo_len + 8'd1);
    end
  end

  p_sdi_mode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnv_o) |-> (sdi_o == !mode_i));
  p_sdi_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnv_o) |-> $stable(sdi_o));
  p_sck_low_at_cnv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnv_o) |-> (!sck_o && lo_len != 8'd0));
  p_cs_cnv_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && !mode_i) |-> !cnv_o);
  p_chain_cnv_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && mode_i) |-> cnv_o);
  p_sck_high_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sck_o) |-> (hi_len >= 8'(HI_C)));
  p_sck_low_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> (lo_len >= 8'(LO_C)));
  p_valid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
  p_idx_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (int'(dev_idx_o) < int'(N_DEV)));
  p_mode_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnv_o && $past(cnv_o)) |-> $stable(mode_i));
endmodule

bind sar_rd_ctrl sar_rd_chk #(
  .N_DEV(N_DEV), .HI_C(HI_C), .LO_C(LO_C), .IW(IW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnv_o(cnv_o), .sck_o(sck_o), .sdi_o(sdi_o),
  .res_valid_o(res_valid_o), .dev_idx_o(dev_idx_o), .mode_i(mode_w)
);

// File: tb/sar_rd_ctrl_test.sv
`timescale 1ns/1ps
module sar_rd_ctrl_test;
  localparam int N_DEV = 2;
  localparam int DW    = 14;
  // row: [18] chain mode, [17:14] conversions, [13:0] seed
  localparam logic [18:0] VEC [6] = '{
    {1'b0, 4'd1, 14'h0000},
    {1'b0, 4'd2, 14'h3FFF},
    {1'b1, 4'd1, 14'h1234},
    {1'b1, 4'd3, 14'h3FFF},
    {1'b0, 4'd3, 14'h2AAA},
    {1'b1, 4'd2, 14'h0000}
  };

  logic clk = 1'b0;
  logic rst_ni, run_i, chain_i, sdo_i;
  logic cnv_o, sck_o, sdi_o, res_valid_o;
  logic [DW-1:0] res_data_o;
  logic [0:0]    dev_idx_o;

  always #2 clk = ~clk;

  sar_rd_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run_i), .chain_i(chain_i),
    .cnv_o(cnv_o), .sck_o(sck_o), .sdi_o(sdi_o), .sdo_i(sdo_i),
    .res_valid_o(res_valid_o), .res_data_o(res_data_o), .dev_idx_o(dev_idx_o)
  );

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [13:0] fval(input logic [13:0] s, input int f, input int k);
    return s ^ 14'(f * 32'h0B6D) ^ 14'(k * 32'h2A5A);
  endfunction

  // converter models
  logic [13:0] sr [N_DEV];
  logic [13:0] cur_seed = '0;
  int          row_frame = 0, falls_n = 0;
  bit          m_chain = 0, exp_chain = 0, had_read = 0, any_rise = 0;
  realtime     t_rise = -1.0e9, t_sfall = -1.0e9, t_srise = -1.0e9, t_sdi = -1.0e9;

  assign sdo_i = (m_chain || !cnv_o) ? sr[0][13] : 1'b1;

  always @(sdi_o) t_sdi = $realtime;

  always @(posedge cnv_o) begin
    m_chain = !sdi_o;
    chk(m_chain == exp_chain, "R2 mode at convert edge", int'(m_chain), int'(exp_chain));
    chk($realtime - t_sdi >= 30.0, "R2 sdi setup ns", int'($realtime - t_sdi), 30);
    chk(!sck_o && ($realtime - t_sfall >= 5.0), "R3 sck low before convert", int'(sck_o), 0);
    if (any_rise)
      chk($realtime - t_rise >= 5000.0, "R9 convert spacing ns", int'($realtime - t_rise), 5000);
    if (had_read)
      chk($realtime - t_sfall >= 1800.0, "R9 acquisition ns", int'($realtime - t_sfall), 1800);
    t_rise = $realtime;
    any_rise = 1;
    had_read = 0;
    for (int k = 0; k < N_DEV; k++) sr[k] = fval(cur_seed, row_frame, k);
    row_frame++;
  end

  always @(negedge cnv_o)
    chk($realtime - t_rise >= 10.0, "R4 convert high ns", int'($realtime - t_rise), 10);

  always @(posedge sck_o) begin
    chk($realtime - t_rise >= 3200.0, "R3 conversion wait ns", int'($realtime - t_rise), 3200);
    chk($realtime - t_sfall >= 12.0, "R6 sck low ns", int'($realtime - t_sfall), 12);
    chk(cnv_o == m_chain, "R4/R5 convert level in readout", int'(cnv_o), int'(m_chain));
    if (t_srise > t_rise)
      chk($realtime - t_srise >= 29.0, "R6 sck period ns", int'($realtime - t_srise), 29);
    t_srise = $realtime;
  end

  always @(negedge sck_o) begin
    chk($realtime - t_srise >= 12.0, "R6 sck high ns", int'($realtime - t_srise), 12);
    t_sfall = $realtime;
    had_read = 1;
    falls_n++;
    #20;
    for (int k = 0; k < N_DEV - 1; k++) sr[k] = {sr[k][12:0], sr[k+1][13]};
    sr[N_DEV-1] = {sr[N_DEV-1][12:0], sdi_o};
  end

  // result collector
  logic [13:0] got_d [32];
  int          got_i [32];
  int          got_n = 0;
  always @(negedge clk) if (res_valid_o && got_n < 32) begin
    got_d[got_n] = res_data_o;
    got_i[got_n] = int'(dev_idx_o);
    got_n++;
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  task automatic wait_words(input int want);
    while (got_n < want) @(posedge clk);
    #1;
  endtask

  initial begin
    for (int k = 0; k < N_DEV; k++) sr[k] = '0;
    rst_ni = 0; run_i = 0; chain_i = 0;
    repeat (5) @(negedge clk);
    chk(cnv_o == 0, "R1 reset cnv", int'(cnv_o), 0);
    chk(sck_o == 0, "R1 reset sck", int'(sck_o), 0);
    chk(sdi_o == 0, "R1 reset sdi", int'(sdi_o), 0);
    chk(res_valid_o == 0, "R1 reset valid", int'(res_valid_o), 0);
    rst_ni = 1;
    repeat (50) @(negedge clk);
    chk(row_frame == 0, "R1 idle after reset", row_frame, 0);

    for (int r = 0; r < 6; r++) begin
      automatic bit   md   = VEC[r][18];
      automatic int   nf   = int'(VEC[r][17:14]);
      automatic int   per  = md ? N_DEV : 1;
      automatic int   want = nf * per;
      automatic int   fr_end;
      cur_seed = VEC[r][13:0]; row_frame = 0; got_n = 0; falls_n = 0;
      exp_chain = md; chain_i = md;
      run_i = 1;
      // stop once the last wanted conversion has started
      while (row_frame < nf) @(posedge clk);
      #1 run_i = 0;
      wait_words(want);
      repeat (1500) @(negedge clk);
      fr_end = row_frame;
      chk(fr_end == nf, "R10 conversions per row", fr_end, nf);
      chk(got_n == want, "R8 word count", got_n, want);
      chk(falls_n == nf * per * DW, "R7 falling edges", falls_n, nf * per * DW);
      for (int j = 0; j < want && j < got_n; j++) begin
        chk(got_d[j] == fval(cur_seed, j / per, j % per), "R8 word data",
            int'(got_d[j]), int'(fval(cur_seed, j / per, j % per)));
        chk(got_i[j] == j % per, "R8 device index", got_i[j], j % per);
      end
    end

    // R11: chain_i flips during a select-mode conversion
    cur_seed = 14'h155A; row_frame = 0; got_n = 0; falls_n = 0;
    exp_chain = 0; chain_i = 0; run_i = 1;
    while (row_frame < 1) @(posedge clk);
    #1 chain_i = 1; run_i = 0;
    repeat (2500) @(negedge clk);
    chk(got_n == 1, "R11 word count after mode flip", got_n, 1);
    chk(falls_n == DW, "R11 falling edges after mode flip", falls_n, DW);
    chk(got_d[0] == fval(14'h155A, 0, 0), "R11 word data", int'(got_d[0]), int'(fval(14'h155A, 0, 0)));
    chk(sdi_o == 0, "R11 sdi back to idle", int'(sdi_o), 0);

    // R10: run low keeps the block idle
    row_frame = 0;
    repeat (3000) @(negedge clk);
    chk(row_frame == 0, "R10 no conversion with run low", row_frame, 0);

    // R1: reset during a chain conversion
    got_n = 0; exp_chain = 1; chain_i = 1; run_i = 1;
    while (row_frame < 1) @(posedge clk);
    repeat (100) @(posedge clk);
    #1 rst_ni = 0; run_i = 0;
    #1;
    chk(cnv_o == 0, "R1 cnv low in reset", int'(cnv_o), 0);
    chk(sck_o == 0, "R1 sck low in reset", int'(sck_o), 0);
    chk(sdi_o == 0, "R1 sdi low in reset", int'(sdi_o), 0);
    repeat (5) @(negedge clk);
    rst_ni = 1;
    repeat (2000) @(negedge clk);
    chk(got_n == 0, "R1 no words from aborted conversion", got_n, 0);
    chk(row_frame == 1, "R1 no restart after reset", row_frame, 1);
    finish_run();
  end
endmodule